// File: doc/BRIEF.md
# Burst Memory Access Sequencer

This block drives one read or write burst at a time on a synchronous burst-mode memory bank. A request carries a start address, a direction and a word count. The block first spends one cycle presenting the address. It then spends one cycle on each data word, with the column advancing by one each cycle. A burst of m words that stays inside one row therefore takes m+1 memory cycles, where m separate accesses would take 2m.

The internal address is split into a row field, a bank field and a column field. When a burst runs past the last column of a row, it does not move to the next row of the same bank. It moves to the same row of the next internal bank, at column zero. The row field advances only when the bank field wraps. Each such crossing costs one extra address cycle before data resumes. The block reports the number of memory cycles each burst used, so the m+1 cost can be checked directly.

Top module: `burst_seq_top`

## Requirements
- R1: After reset, req_ready is 1, addr_strobe, data_strobe and burst_done are 0, and cycle_count is 0.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1. From the next cycle, req_ready is 0 until the cycle in which burst_done is 1; req_ready is 1 again in that cycle.
- R3: In the cycle after a request is taken, addr_strobe is 1 for exactly one cycle. During that cycle mem_row, mem_bank and mem_col show the start address, which req_addr packs as {row, bank, column} from MSB to LSB.
- R4: After the address cycle, data_strobe is 1 for one cycle per word. Inside a row the data cycles are consecutive, the first one shows the start column, and each following one shows the previous column plus 1.
- R5: mem_write equals the req_write value that was taken with the request, and it holds that value in every address and data cycle of the burst.
- R6: If a data word falls on the last column (all ones) and more words remain, the next cycle is an address cycle. In that cycle the bank is one higher, the row is unchanged and the column is 0, and data resumes in the cycle after it.
- R7: If such a crossing starts from the highest bank, the bank wraps to 0 and the row is one higher.
- R8: One cycle after the final data cycle, burst_done is 1 for exactly one cycle. In that cycle cycle_count equals the number of address and data cycles the burst used, which is m+1 plus one for each crossing. cycle_count then holds this value until the next burst completes.
- R9: A request whose length is 0 or greater than MAX_BURST is ignored. It produces no strobe, req_ready stays 1 and cycle_count is unchanged.
- R10: While req_ready is 0, req_valid has no effect. The running burst is unchanged, and once it completes no new burst starts unless a request is presented while req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | ROW_W+BANK_W+COL_W | Start address {row, bank, column} |
| req_len | input | LEN_W | Number of words, 1 to MAX_BURST |
| addr_strobe | output | 1 | Address cycle in progress |
| data_strobe | output | 1 | Data word cycle in progress |
| mem_write | output | 1 | Direction of the current burst |
| mem_row | output | ROW_W | Current row |
| mem_bank | output | BANK_W | Current internal bank |
| mem_col | output | COL_W | Current column |
| burst_done | output | 1 | One-cycle pulse when a burst has finished |
| cycle_count | output | CNT_W | Memory cycles used by the last finished burst |

## Verification
The bench builds the block with 8-word rows (COL_W=3), four internal banks (BANK_W=2), eight rows (ROW_W=3) and MAX_BURST=16. With rows this short, a single 16-word burst crosses two row ends. A short burst that starts in the top bank reaches the bank wrap with a row increment. A burst that starts in the top row and top bank wraps the whole address to zero. The limit of 16 makes it cheap to test a length one above the maximum.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ADDR = 2'd1,
      ST_DATA = 2'd2
   } seq_state_t;

endpackage

// File: rtl/burst_addr_step.sv
module burst_addr_step #(
   parameter int ROW_W  = 4,
   parameter int BANK_W = 2,
   parameter int COL_W  = 5
) (
   input  logic [ROW_W-1:0]  cur_row,
   input  logic [BANK_W-1:0] cur_bank,
   input  logic [COL_W-1:0]  cur_col,
   output logic [ROW_W-1:0]  nxt_row,
   output logic [BANK_W-1:0] nxt_bank,
   output logic [COL_W-1:0]  nxt_col,
   output logic              row_end
);

   logic bank_top;

   always_comb begin
      row_end  = &cur_col;
      bank_top = &cur_bank;
      nxt_col  = cur_col + 1'b1;
      // bank advances before row: row only moves when the bank wraps
      nxt_bank = row_end ? cur_bank + 1'b1 : cur_bank;
      nxt_row  = (row_end && bank_top) ? cur_row + 1'b1 : cur_row;
   end

endmodule

// File: rtl/burst_cycle_meter.sv
module burst_cycle_meter #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             tick,
   input  logic             finish,
   output logic [CNT_W-1:0] total
);

   logic [CNT_W-1:0] run_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= '0;
         total <= '0;
      end else begin
         if (start)
            run_q <= '0;
         else if (tick)
            run_q <= run_q + 1'b1;
         if (finish)
            total <= run_q + 1'b1;
      end
   end

   // any finished burst used at least an address and a data cycle
   p_total_min_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      finish |=> (total >= CNT_W'(2)));

endmodule

// File: rtl/burst_seq_top.sv
module burst_seq_top
   import burst_seq_pkg::*;
#(
   parameter int ROW_W     = 4,
   parameter int BANK_W    = 2,
   parameter int COL_W     = 5,
   parameter int MAX_BURST = 32,
   localparam int ADDR_W   = ROW_W + BANK_W + COL_W,
   localparam int LEN_W    = $clog2(MAX_BURST + 1),
   localparam int CNT_W    = $clog2(2 * MAX_BURST + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   output logic              addr_strobe,
   output logic              data_strobe,
   output logic              mem_write,
   output logic [ROW_W-1:0]  mem_row,
   output logic [BANK_W-1:0] mem_bank,
   output logic [COL_W-1:0]  mem_col,
   output logic              burst_done,
   output logic [CNT_W-1:0]  cycle_count
);

   localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(MAX_BURST);

   if (ROW_W < 1 || BANK_W < 1 || COL_W < 1) begin : g_bad_fields
      $error("burst_seq_top: every address field needs at least one bit");
   end
   if (MAX_BURST < 1) begin : g_bad_len
      $error("burst_seq_top: MAX_BURST must be at least 1");
   end

   seq_state_t        st_q;
   logic [ROW_W-1:0]  row_q;
   logic [BANK_W-1:0] bank_q;
   logic [COL_W-1:0]  col_q;
   logic [LEN_W-1:0]  left_q;
   logic              wr_q;
   logic              done_q;

   logic [ROW_W-1:0]  row_n;
   logic [BANK_W-1:0] bank_n;
   logic [COL_W-1:0]  col_n;
   logic              at_row_end;
   logic              len_ok;
   logic              take;
   logic              last_word;

   burst_addr_step #(
      .ROW_W (ROW_W),
      .BANK_W(BANK_W),
      .COL_W (COL_W)
   ) u_step (
      .cur_row (row_q),
      .cur_bank(bank_q),
      .cur_col (col_q),
      .nxt_row (row_n),
      .nxt_bank(bank_n),
      .nxt_col (col_n),
      .row_end (at_row_end)
   );

   always_comb begin
      len_ok    = (req_len != '0) && (req_len <= MAX_LEN);
      take      = req_valid && req_ready && len_ok;
      last_word = (st_q == ST_DATA) && (left_q == LEN_W'(1));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         row_q  <= '0;
         bank_q <= '0;
         col_q  <= '0;
         left_q <= '0;
         wr_q   <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (take) begin
                  st_q   <= ST_ADDR;
                  {row_q, bank_q, col_q} <= req_addr;
                  left_q <= req_len;
                  wr_q   <= req_write;
               end
            end
            ST_ADDR: begin
               st_q <= ST_DATA;
            end
            ST_DATA: begin
               if (last_word) begin
                  st_q   <= ST_IDLE;
                  done_q <= 1'b1;
               end else begin
                  left_q <= left_q - 1'b1;
                  row_q  <= row_n;
                  bank_q <= bank_n;
                  col_q  <= col_n;
                  st_q   <= at_row_end ? ST_ADDR : ST_DATA;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   burst_cycle_meter #(
      .CNT_W(CNT_W)
   ) u_meter (
      .clk   (clk),
      .rst_n (rst_n),
      .start (take),
      .tick  (st_q != ST_IDLE),
      .finish(last_word),
      .total (cycle_count)
   );

   always_comb begin
      req_ready   = (st_q == ST_IDLE);
      addr_strobe = (st_q == ST_ADDR);
      data_strobe = (st_q == ST_DATA);
      mem_write   = wr_q;
      mem_row     = row_q;
      mem_bank    = bank_q;
      mem_col     = col_q;
      burst_done  = done_q;
   end

   p_ready_quiet_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !(addr_strobe || data_strobe));

   p_addr_first_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && len_ok) |=>
         (addr_strobe && ({mem_row, mem_bank, mem_col} == $past(req_addr))));

   p_addr_then_data_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      addr_strobe |=> data_strobe);

   p_col_step_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (data_strobe && $past(data_strobe)) |-> (mem_col == $past(mem_col) + 1'b1));

   p_dir_hold_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      data_strobe |-> $stable(mem_write));

   p_cross_bank_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (addr_strobe && $past(data_strobe)) |->
         ((mem_col == '0) && (mem_bank == $past(mem_bank) + 1'b1)));

   p_cross_row_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (addr_strobe && $past(data_strobe) && (mem_bank == '0)) |->
         (mem_row == $past(mem_row) + 1'b1));

   p_done_pulse_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      burst_done |=> !burst_done);

   p_bad_len_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && req_valid && !len_ok) |=> (req_ready && !addr_strobe));

endmodule

// File: tb/burst_seq_top_test.sv
module burst_seq_top_test;

   localparam int ROW_W     = 3;
   localparam int BANK_W    = 2;
   localparam int COL_W     = 3;
   localparam int MAX_BURST = 16;
   localparam int ADDR_W    = ROW_W + BANK_W + COL_W;
   localparam int LEN_W     = $clog2(MAX_BURST + 1);
   localparam int CNT_W     = $clog2(2 * MAX_BURST + 2);
   localparam int VW        = 1 + ADDR_W + LEN_W;
   localparam int NVEC      = 6;

   // each entry: {write, row, bank, col, length}
   localparam logic [VW-1:0] VEC [NVEC] = '{
      {1'b0, 3'd1, 2'd0, 3'd0, 5'd4},
      {1'b1, 3'd2, 2'd1, 3'd6, 5'd4},
      {1'b0, 3'd3, 2'd3, 3'd5, 5'd5},
      {1'b1, 3'd0, 2'd0, 3'd0, 5'd1},
      {1'b0, 3'd5, 2'd2, 3'd7, 5'd16},
      {1'b1, 3'd7, 2'd3, 3'd4, 5'd8}
   };

   logic              clk = 1'b0;
   logic              rst_n;
   logic              req_valid;
   logic              req_ready;
   logic              req_write;
   logic [ADDR_W-1:0] req_addr;
   logic [LEN_W-1:0]  req_len;
   logic              addr_strobe;
   logic              data_strobe;
   logic              mem_write;
   logic [ROW_W-1:0]  mem_row;
   logic [BANK_W-1:0] mem_bank;
   logic [COL_W-1:0]  mem_col;
   logic              burst_done;
   logic [CNT_W-1:0]  cycle_count;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   burst_seq_top #(
      .ROW_W    (ROW_W),
      .BANK_W   (BANK_W),
      .COL_W    (COL_W),
      .MAX_BURST(MAX_BURST)
   ) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .req_write  (req_write),
      .req_addr   (req_addr),
      .req_len    (req_len),
      .addr_strobe(addr_strobe),
      .data_strobe(data_strobe),
      .mem_write  (mem_write),
      .mem_row    (mem_row),
      .mem_bank   (mem_bank),
      .mem_col    (mem_col),
      .burst_done (burst_done),
      .cycle_count(cycle_count)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int where_now();
      return int'({mem_row, mem_bank, mem_col});
   endfunction

   task automatic run_burst(input bit wr, input logic [ADDR_W-1:0] a0,
                            input int len, input bit poke);
      logic [ADDR_W-1:0] a;
      int cyc;
      a = a0;
      @(negedge clk);
      check("R2 ready before request", int'(req_ready), 1);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = a0;
      req_len   = LEN_W'(len);
      @(negedge clk);
      req_valid = 1'b0;
      check("R3 address strobe", int'(addr_strobe), 1);
      check("R3 start address", where_now(), int'(a0));
      check("R2 ready low while busy", int'(req_ready), 0);
      check("R5 direction", int'(mem_write), int'(wr));
      if (poke) begin
         req_valid = 1'b1;
         req_write = ~wr;
         req_addr  = ~a0;
         req_len   = LEN_W'(2);
      end
      cyc = 1;
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         if (poke) req_valid = 1'b0;
         check("R4 data strobe", int'(data_strobe), 1);
         check("R4 column sequence", where_now(), int'(a));
         check("R5 direction held", int'(mem_write), int'(wr));
         cyc++;
         if (i < len - 1 && (&a[COL_W-1:0])) begin
            a = a + 1'b1;
            @(negedge clk);
            check("R6 crossing address cycle", int'(addr_strobe), 1);
            if (a[COL_W +: BANK_W] == '0)
               check("R7 bank wrap moves row", where_now(), int'(a));
            else
               check("R6 next bank same row", where_now(), int'(a));
            cyc++;
         end else begin
            a = a + 1'b1;
         end
      end
      @(negedge clk);
      check("R8 done pulse", int'(burst_done), 1);
      check("R8 cycle count", int'(cycle_count), cyc);
      check("R2 ready with done", int'(req_ready), 1);
      @(negedge clk);
      check("R8 done one cycle", int'(burst_done), 0);
      check("R8 count held", int'(cycle_count), cyc);
      if (poke) begin
         check("R10 no burst from busy request", int'(addr_strobe), 0);
         check("R10 still idle", int'(req_ready), 1);
      end
   endtask

   task automatic bad_len(input int len, input int prev);
      @(negedge clk);
      req_valid = 1'b1;
      req_write = 1'b1;
      req_addr  = '0;
      req_len   = LEN_W'(len);
      @(negedge clk);
      req_valid = 1'b0;
      check("R9 no strobe on bad length", int'(addr_strobe || data_strobe), 0);
      check("R9 ready stays", int'(req_ready), 1);
      @(negedge clk);
      check("R9 still no strobe", int'(addr_strobe || data_strobe), 0);
      check("R9 count unchanged", int'(cycle_count), prev);
   endtask

   initial begin
      rst_n     = 1'b0;
      req_valid = 1'b0;
      req_write = 1'b0;
      req_addr  = '0;
      req_len   = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 ready after reset", int'(req_ready), 1);
      check("R1 strobes after reset", int'(addr_strobe || data_strobe), 0);
      check("R1 done after reset", int'(burst_done), 0);
      check("R1 count after reset", int'(cycle_count), 0);

      for (int v = 0; v < NVEC; v++) begin
         run_burst(VEC[v][VW-1], VEC[v][LEN_W +: ADDR_W],
                   int'(VEC[v][LEN_W-1:0]), 1'b0);
      end

      // last table entry: 8 words from col 4 of top bank, top row: 9 + 1 = 10
      bad_len(0, 10);
      bad_len(MAX_BURST + 1, 10);
      run_burst(1'b0, {3'd4, 2'd1, 3'd2}, 3, 1'b1);
      run_burst(1'b1, {3'd6, 2'd0, 3'd0}, MAX_BURST, 1'b0);

      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures",
                  n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      #(200000 * 10);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures",
                  n_checks, n_fails);
         $finish;
      end
   end

endmodule